// File: doc/BRIEF.md
# Flash Halfword Program Engine

This block models the array side of a flash device that programs one 16-bit halfword at a time. A bus master unlocks the engine with three fixed command writes. The fourth write supplies an even byte address and the data word. The engine then runs a timed internal program cycle. It never sets a bit: each programmed cell keeps the AND of its old contents and the new data. Returning bits to one is done only by a whole-array erase input.

While the program cycle runs, reads return a status word instead of array data. The status word carries three flags: an inverted copy of bit 7 of the data being programmed, a bit that flips on each read, and a time-limit flag. If the new data asks for any 0 to become 1, the cycle never completes. When the time limit runs out, the engine raises the time-limit flag and freezes the flipping bit in the same read. It then stays in status mode until a reset command is written. Command writes that arrive during the cycle are dropped.

The write time and the time limit are parameters counted in clock cycles. The time limit must be larger than the write time. The array depth is a power-of-two parameter, and the array is indexed by the halfword address bits.

Top module: `flash_prog_engine`

## Requirements
- R1: The program sequence is three writes followed by a target write. The three writes are: address 0xAAA with low data byte 0xAA, then address 0x554 with 0x55, then address 0xAAA with 0xA0. A write that does not match the expected step returns the decoder to read mode, and no program takes place.
- R2: The target write must have address bit 0 clear. An odd target address starts no program, returns to read mode and leaves the array unchanged.
- R3: A program leaves the addressed word equal to its old value ANDed with the new data. Targets may be given in any order and anywhere in the array.
- R4: A program whose data sets no 0 bit to 1 finishes WRITE_CYCLES clock cycles after the cycle that accepted the target write. From then on, reads return array data.
- R5: A read during a program returns a status word with these bits: bit 7 is the inverse of bit 7 of the programmed data, bit 6 is the toggle bit, bit 5 is the time-limit flag (0 while running), and all other bits are 0. The toggle bit reads 0 on the first read after acceptance and inverts on each later read.
- R6: Writes presented while a program runs are ignored. This holds in its final cycle too, and these writes do not advance the unlock decoder.
- R7: If the data asks for any 0 to become 1, the program does not finish. Starting TIME_LIMIT cycles after acceptance, reads show bit 5 = 1 and bit 6 stops inverting, from the same read onward.
- R8: After a time-limit failure, status mode holds until a write with low data byte 0xF0. After that write, reads return the array, which holds old AND new.
- R9: Pulsing `eraseAll` in read mode sets every word to 0xFFFF. It is ignored while a program runs or a failure is held.
- R10: `busRdata` is 0 after reset. It changes only in the cycle after a cycle with `busRe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eraseAll | input | 1 | Set every array word to all ones (read mode only) |
| busWe | input | 1 | Bus write strobe |
| busRe | input | 1 | Bus read strobe |
| busAddr | input | ADDR_W | Byte address for reads and writes |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, registered, one cycle after `busRe` |

## Verification
Two events can fall in the same cycle: the last cycle of the internal program and a bus access. The array commit happens at the end of that cycle, so a read there must still return status. A command write there must still be dropped, even though the engine is back in read mode one edge later. The bench issues a read and the first unlock write together in exactly that cycle. It then reads the array in the next cycle and completes the remaining command steps. It checks three things: the status value, the new data one cycle later, and that the late sequence programmed nothing. The failure path is judged in the same spirit. Reads are issued in every cycle across the time limit, so the single read where the limit flag rises and the toggle freezes is compared directly.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  typedef enum logic [2:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_ARMED,
    ST_BUSY,
    ST_FAIL
  } engState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;     // latch target address/data, clear toggle
    logic commit;      // AND new data into the target word
    logic wipe;        // set whole array to ones
    logic togStep;     // invert toggle bit on this read
    logic showStatus;  // reads return status instead of array
    logic failFlag;    // time limit expired
  } dpStrobe_t;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  KEY_PROG   = 8'hA0;
  localparam logic [7:0]  KEY_RESET  = 8'hF0;
  localparam logic [11:0] UNLOCK_ADDR_A = 12'hAAA;
  localparam logic [11:0] UNLOCK_ADDR_B = 12'h554;

  localparam int FLAG_POLL   = 7;
  localparam int FLAG_TOGGLE = 6;
  localparam int FLAG_LIMIT  = 5;

endpackage

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 20,
  parameter int TIME_LIMIT   = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        keyByte,
  input  logic              eraseAll,
  input  logic              badBits,
  output dpStrobe_t         strobe,
  output engState_t         state
);

  localparam int CNT_W = $clog2(TIME_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_WRITE = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_LIMIT = CNT_W'(TIME_LIMIT - 1);

  engState_t        stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             hitA, hitB;

  assign hitA = (busAddr == ADDR_W'(UNLOCK_ADDR_A));
  assign hitB = (busAddr == ADDR_W'(UNLOCK_ADDR_B));

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    strobe.showStatus = (state == ST_BUSY) || (state == ST_FAIL);
    strobe.failFlag   = (state == ST_FAIL);
    strobe.togStep    = busRe && (state == ST_BUSY);
    strobe.wipe       = eraseAll && !strobe.showStatus;
    case (state)
      ST_READ: begin
        if (busWe && hitA && keyByte == KEY_FIRST) stateNext = ST_UNL1;
      end
      ST_UNL1: begin
        if (busWe) stateNext = (hitB && keyByte == KEY_SECOND) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (busWe) stateNext = (hitA && keyByte == KEY_PROG) ? ST_ARMED : ST_READ;
      end
      ST_ARMED: begin
        if (busWe) begin
          if (!busAddr[0]) begin
            strobe.capture = 1'b1;
            cntNext        = '0;
            stateNext      = ST_BUSY;
          end else begin
            stateNext = ST_READ;
          end
        end
      end
      ST_BUSY: begin
        cntNext = cnt + CNT_W'(1);
        if (cnt == LAST_WRITE) begin
          strobe.commit = 1'b1;
          if (!badBits) stateNext = ST_READ;
        end
        if (cnt == LAST_LIMIT) stateNext = ST_FAIL;
      end
      ST_FAIL: begin
        if (busWe && keyByte == KEY_RESET) stateNext = ST_READ;
      end
      default: stateNext = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_READ;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/flash_prog_dpath.sv
module flash_prog_dpath
  import flash_prog_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ARRAY_WORDS = 64,
  parameter int IDX_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              busRe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              badBits,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [ARRAY_WORDS];
  logic [IDX_W-1:0]  tgtIdx;
  logic [DATA_W-1:0] tgtData;
  logic              togReg;
  logic [DATA_W-1:0] statusWord;

  // a 1 requested where the cell already holds 0 can never be programmed
  assign badBits = |(~mem[tgtIdx] & tgtData);

  always_comb begin
    statusWord              = '0;
    statusWord[FLAG_POLL]   = ~tgtData[FLAG_POLL];
    statusWord[FLAG_TOGGLE] = togReg;
    statusWord[FLAG_LIMIT]  = strobe.failFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtIdx  <= '0;
      tgtData <= '0;
      togReg  <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.capture) begin
        tgtIdx  <= wordIdx;
        tgtData <= wrData;
      end
      if (strobe.capture)      togReg <= 1'b0;
      else if (strobe.togStep) togReg <= ~togReg;
      if (busRe) rdData <= strobe.showStatus ? statusWord : mem[wordIdx];
    end
  end

  // array cells: no reset, contents are established by erase
  always_ff @(posedge clk) begin
    for (int i = 0; i < ARRAY_WORDS; i++) begin
      if (strobe.wipe)
        mem[i] <= '1;
      else if (strobe.commit && tgtIdx == IDX_W'(i))
        mem[i] <= mem[i] & tgtData;
    end
  end

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 16,
  parameter int ARRAY_WORDS  = 64,
  parameter int WRITE_CYCLES = 20,
  parameter int TIME_LIMIT   = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eraseAll,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  localparam int IDX_W = $clog2(ARRAY_WORDS);

  engState_t ctrlState;
  dpStrobe_t strobe;
  logic      badBits;

  flash_prog_ctrl #(
    .ADDR_W      (ADDR_W),
    .WRITE_CYCLES(WRITE_CYCLES),
    .TIME_LIMIT  (TIME_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .keyByte (busWdata[7:0]),
    .eraseAll(eraseAll),
    .badBits (badBits),
    .strobe  (strobe),
    .state   (ctrlState)
  );

  flash_prog_dpath #(
    .DATA_W     (DATA_W),
    .ARRAY_WORDS(ARRAY_WORDS),
    .IDX_W      (IDX_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .busRe  (busRe),
    .wordIdx(busAddr[IDX_W:1]),
    .wrData (busWdata),
    .badBits(badBits),
    .rdData (busRdata)
  );

endmodule

// File: rtl/flash_prog_checker.sv
module flash_prog_checker
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic              busRe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        keyByte,
  input logic [DATA_W-1:0] busRdata,
  input engState_t         ctrlState
);

  assert_unlock_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_READ && !(busWe && busAddr == ADDR_W'(UNLOCK_ADDR_A) && keyByte == KEY_FIRST))
    |=> ctrlState == ST_READ);

  assert_odd_reject_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_ARMED && busWe && busAddr[0]) |=> ctrlState == ST_READ);

  assert_status_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && ctrlState == ST_BUSY)
    |=> (busRdata[DATA_W-1:8] == '0 && busRdata[4:0] == '0 && !busRdata[FLAG_LIMIT]));

  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == ST_BUSY
    |=> (ctrlState != ST_UNL1 && ctrlState != ST_UNL2 && ctrlState != ST_ARMED));

  assert_limit_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && ctrlState == ST_FAIL) |=> busRdata[FLAG_LIMIT]);

  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_FAIL && !(busWe && keyByte == KEY_RESET)) |=> ctrlState == ST_FAIL);

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> $stable(busRdata));

endmodule

bind flash_prog_engine flash_prog_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busRe    (busRe),
  .busAddr  (busAddr),
  .keyByte  (busWdata[7:0]),
  .busRdata (busRdata),
  .ctrlState(ctrlState)
);

// File: tb/flash_prog_engine_bench.sv
module flash_prog_engine_bench;

  localparam int W = 6;
  localparam int L = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        eraseAll = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;

  int vecCnt = 0;
  int failCnt = 0;
  bit checking = 1'b0;
  string curReq = "R10";

  always #4 clk = ~clk;

  flash_prog_engine #(
    .ADDR_W(12), .DATA_W(16), .ARRAY_WORDS(64),
    .WRITE_CYCLES(W), .TIME_LIMIT(L)
  ) u_flash_prog_engine (
    .clk(clk), .rstN(rstN), .eraseAll(eraseAll), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  // behavioural reference: mode 0 idle, 1..3 unlock steps seen, 4 programming, 5 failed
  logic [15:0] mMem [64];
  int          mMode = 0;
  int          mTick = 0;
  int          mIdx = 0;
  int          curIdx;
  logic [15:0] mData = '0;
  bit          mTog = 1'b0;
  bit          mBad;
  logic [15:0] expR = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; expR = '0; mTog = 1'b0;
    end else begin
      curIdx = int'(busAddr[6:1]);
      if (busRe) begin
        if (mMode >= 4) expR = {8'h00, ~mData[7], mTog, (mMode == 5), 5'b00000};
        else            expR = mMem[curIdx];
        if (mMode == 4) mTog = !mTog;
      end
      if (eraseAll && mMode < 4) foreach (mMem[i]) mMem[i] = 16'hFFFF;
      if (mMode == 4) begin
        if (mTick == W - 1) begin
          mBad = ((~mMem[mIdx]) & mData) != 16'h0000;
          mMem[mIdx] = mMem[mIdx] & mData;
          if (!mBad) mMode = 0;
        end
        if (mTick == L - 1) mMode = 5;
        mTick++;
      end else if (mMode == 5) begin
        if (busWe && busWdata[7:0] == 8'hF0) mMode = 0;
      end else if (busWe) begin
        case (mMode)
          0: mMode = (busAddr == 12'hAAA && busWdata[7:0] == 8'hAA) ? 1 : 0;
          1: mMode = (busAddr == 12'h554 && busWdata[7:0] == 8'h55) ? 2 : 0;
          2: mMode = (busAddr == 12'hAAA && busWdata[7:0] == 8'hA0) ? 3 : 0;
          default: begin
            if (!busAddr[0]) begin
              mIdx = curIdx; mData = busWdata; mTick = 0; mTog = 1'b0; mMode = 4;
            end else mMode = 0;
          end
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      vecCnt++;
      if (busRdata !== expR) begin
        failCnt++;
        $display("FAIL %s: busRdata actual %h expected %h at %0t", curReq, busRdata, expR, $time);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    busRe = 1'b1; busAddr = a;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [11:0] a, input logic [15:0] exp, input string req);
    rd(a);
    vecCnt++;
    if (busRdata !== exp) begin
      failCnt++;
      $display("FAIL %s: read %h actual %h expected %h", req, a, busRdata, exp);
    end
  endtask

  task automatic prog(input logic [11:0] a, input logic [15:0] d);
    wr(12'hAAA, 16'h00AA);
    wr(12'h554, 16'h0055);
    wr(12'hAAA, 16'h00A0);
    wr(a, d);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    report();
  end

  initial begin
    idle(3);
    vecCnt++;
    if (busRdata !== 16'h0000) begin  // R10 reset value
      failCnt++;
      $display("FAIL R10: reset busRdata actual %h expected 0000", busRdata);
    end
    rstN = 1'b1;
    checking = 1'b1;
    idle(1);

    curReq = "R9";
    eraseAll = 1'b1; idle(1); eraseAll = 1'b0;
    chk(12'h000, 16'hFFFF, "R9");
    chk(12'h07E, 16'hFFFF, "R9");

    curReq = "R4";
    prog(12'h010, 16'h1234); idle(W + 2);
    chk(12'h010, 16'h1234, "R4");

    curReq = "R3";
    prog(12'h010, 16'h1030); idle(W + 2);
    chk(12'h010, 16'h1030, "R3");
    prog(12'h07E, 16'hBEEF); idle(W + 2);
    prog(12'h002, 16'h0F0F); idle(W + 2);
    chk(12'h07E, 16'hBEEF, "R3");
    chk(12'h002, 16'h0F0F, "R3");

    curReq = "R1";
    wr(12'hAAA, 16'h00AA); wr(12'h554, 16'h0056); wr(12'hAAA, 16'h00A0);
    wr(12'h020, 16'h0000); idle(W + 2);
    chk(12'h020, 16'hFFFF, "R1");

    curReq = "R2";
    prog(12'h021, 16'h0000); idle(W + 2);
    chk(12'h020, 16'hFFFF, "R2");

    curReq = "R5";
    prog(12'h030, 16'h0055);
    chk(12'h030, 16'h0080, "R5");
    chk(12'h030, 16'h00C0, "R5");
    idle(W);
    chk(12'h030, 16'h0055, "R4");

    curReq = "R6";
    prog(12'h040, 16'h00FF);
    wr(12'hAAA, 16'h00AA); wr(12'h554, 16'h0055); wr(12'hAAA, 16'h00A0);
    wr(12'h042, 16'h0000);
    idle(W);
    chk(12'h040, 16'h00FF, "R6");
    chk(12'h042, 16'hFFFF, "R6");

    // read and first unlock write together in the last programming cycle
    prog(12'h044, 16'h1111);
    idle(W - 1);
    busRe = 1'b1; busWe = 1'b1; busAddr = 12'hAAA; busWdata = 16'h00AA;
    @(negedge clk);
    busRe = 1'b0; busWe = 1'b0;
    vecCnt++;
    if (busRdata !== 16'h0080) begin
      failCnt++;
      $display("FAIL R6: last-cycle read actual %h expected 0080", busRdata);
    end
    chk(12'h044, 16'h1111, "R4");
    wr(12'h554, 16'h0055); wr(12'hAAA, 16'h00A0); wr(12'h044, 16'h0000);
    idle(W + 2);
    chk(12'h044, 16'h1111, "R6");

    curReq = "R7";
    prog(12'h008, 16'h00FF); idle(W + 2);
    prog(12'h008, 16'hFF00);
    for (int k = 0; k < L + 3; k++) rd(12'h008);
    chk(12'h008, 16'h00E0, "R7");

    curReq = "R8";
    eraseAll = 1'b1; idle(1); eraseAll = 1'b0;
    wr(12'h008, 16'h0000);
    chk(12'h008, 16'h00E0, "R8");
    wr(12'h000, 16'h00F0);
    chk(12'h008, 16'h0000, "R8");
    chk(12'h008, 16'h0000, "R9");

    idle(2);
    report();
  end

endmodule